// File: doc/BRIEF.md
# Pointer-Addressed Byte Store for a Block Cipher

This block holds the 16-byte working block of a cipher engine. A processor reaches every byte through one data register address. Two hidden pointers, one for reads and one for writes, select the byte. Each pointer advances by one after every access it serves, so the processor can load or dump the whole block with sixteen back-to-back accesses. The processor cannot see or set the pointers. It can only clear them, and it does so by touching the control register.

An XOR write mode folds each incoming byte into the byte at the read pointer and stores the result at the write pointer. Both pointers then advance. While the cipher core reports that an operation is running, the processor's data accesses are shut out. Through a separate side port, the cipher core reads all 128 bits in parallel and replaces the whole contents with a single load strobe.

Top module: `ptr_state_mem`

## Requirements
- R1: After reset, all sixteen entries are zero and both pointers are zero, so the first read returns entry 0 and the first write lands in entry 0.
- R2: A data write (`bus_wr` high, `xor_en` low, `core_busy` low) stores `wdata` in the entry at the write pointer, and the write pointer then advances by one at the clock edge.
- R3: During a cycle with `bus_rd` high and `core_busy` low, `rdata` shows the entry at the read pointer. The read pointer advances by one at the edge, and the contents do not change.
- R4: Each pointer wraps from entry 15 back to entry 0. A 17th sequential access therefore addresses entry 0 again.
- R5: A `ctrl_acc` strobe clears both pointers to zero and leaves the contents unchanged. It acts even while `core_busy` is high.
- R6: A write with `xor_en` high stores `wdata` XOR (entry at read pointer) into the entry at the write pointer, and both pointers advance by one.
- R7: While `core_busy` is high, a data read returns zero, a data write (plain or XOR) is discarded, and both pointers keep their values.
- R8: `core_dout` presents all entries at all times. Entry i occupies bits [127-8i : 120-8i], so entry 0 is the most significant byte.
- R9: A `core_load` strobe replaces all entries from `core_din`, using the same byte order as R8. It acts regardless of `core_busy` and leaves both pointers unchanged.
- R10: `rdata` is zero in every cycle without a valid read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe for the data register |
| bus_wr | input | 1 | Write strobe for the data register |
| xor_en | input | 1 | Selects XOR write mode, sampled with each write strobe |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor, zero without a valid read |
| ctrl_acc | input | 1 | Strobe marking any access to the control register |
| core_busy | input | 1 | Cipher operation in progress |
| core_load | input | 1 | Parallel load strobe from the cipher core |
| core_din | input | 128 | Parallel load data, entry 0 in the top byte |
| core_dout | output | 128 | Parallel view of all entries, entry 0 in the top byte |

## Verification
A pointer that is off by one or fails to wrap shows up on the very next data access. That read returns a different entry, or that write changes a different byte of `core_dout`, one clock after the strobe. A wrong XOR source or a missed read-pointer step in XOR mode corrupts the stored byte, and `core_dout` exposes it on the following edge. A busy gate that leaks shows either as a nonzero `rdata` during the blocked cycle or as a shifted pointer on the first access after busy falls. The bench sweeps full 16-entry passes and the passes that wrap, and it predicts every byte arithmetically.

// File: rtl/psm_pkg.sv
package psm_pkg;
  // Kind of store request seen at the data register in one cycle
  typedef enum logic [1:0] {
    WR_NONE  = 2'b00,
    WR_PLAIN = 2'b01,
    WR_XOR   = 2'b10
  } wr_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/psm_ptr.sv
module psm_ptr #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST_IDX = PW'(ENTRIES - 1);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = clr | step;
    ptr_d  = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (step) begin
      if (ptr_q == LAST_IDX) ptr_d = '0;
      else                   ptr_d = ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/psm_store.sv
module psm_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned PW      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PW-1:0]         wr_idx,
  input  logic [DW-1:0]         wr_data,
  input  logic                  load_en,
  input  logic [ENTRIES*DW-1:0] load_vec,
  input  logic [PW-1:0]         rd_idx,
  output logic [DW-1:0]         rd_data,
  output logic [ENTRIES*DW-1:0] flat_out
);
  logic [DW-1:0] ent_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int unsigned LSB = (ENTRIES - 1 - i) * DW;
    logic          ent_en;
    logic [DW-1:0] ent_d;

    // Parallel load takes precedence over the byte write port
    always_comb begin
      ent_en = load_en | (wr_en && (wr_idx == PW'(i)));
      ent_d  = load_en ? load_vec[LSB +: DW] : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= '0;
      else if (ent_en) ent_q[i] <= ent_d;
    end

    assign flat_out[LSB +: DW] = ent_q[i];
  end

  assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/psm_access.sv
module psm_access #(
  parameter int unsigned DW = 8
) (
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          xor_en,
  input  logic          core_busy,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_entry,
  output logic          rptr_step,
  output logic          wptr_step,
  output logic          store_en,
  output logic [DW-1:0] store_data,
  output logic [DW-1:0] rdata
);
  import psm_pkg::*;

  wr_kind_e kind;
  logic     rd_ok;

  always_comb begin
    rd_ok = bus_rd & ~core_busy;
    kind  = WR_NONE;
    if (bus_wr && !core_busy) kind = xor_en ? WR_XOR : WR_PLAIN;

    store_en   = (kind != WR_NONE);
    wptr_step  = store_en;
    rptr_step  = rd_ok | (kind == WR_XOR);
    store_data = (kind == WR_XOR) ? (wdata ^ rd_entry) : wdata;
    rdata      = rd_ok ? rd_entry : '0;
  end
endmodule

// File: rtl/ptr_state_mem.sv
module ptr_state_mem #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned DW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic                  xor_en,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic                  ctrl_acc,
  input  logic                  core_busy,
  input  logic                  core_load,
  input  logic [ENTRIES*DW-1:0] core_din,
  output logic [ENTRIES*DW-1:0] core_dout
);
  localparam int unsigned PW = psm_pkg::idx_width(ENTRIES);

  logic [PW-1:0] rptr_q;
  logic [PW-1:0] wptr_q;
  logic          rptr_step;
  logic          wptr_step;
  logic          store_en;
  logic [DW-1:0] store_data;
  logic [DW-1:0] rd_entry;

  psm_access #(.DW(DW)) u_access (
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .xor_en     (xor_en),
    .core_busy  (core_busy),
    .wdata      (wdata),
    .rd_entry   (rd_entry),
    .rptr_step  (rptr_step),
    .wptr_step  (wptr_step),
    .store_en   (store_en),
    .store_data (store_data),
    .rdata      (rdata)
  );

  psm_ptr #(.ENTRIES(ENTRIES), .PW(PW)) u_rptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_acc),
    .step  (rptr_step),
    .ptr   (rptr_q)
  );

  psm_ptr #(.ENTRIES(ENTRIES), .PW(PW)) u_wptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_acc),
    .step  (wptr_step),
    .ptr   (wptr_q)
  );

  psm_store #(.ENTRIES(ENTRIES), .DW(DW), .PW(PW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (store_en),
    .wr_idx   (wptr_q),
    .wr_data  (store_data),
    .load_en  (core_load),
    .load_vec (core_din),
    .rd_idx   (rptr_q),
    .rd_data  (rd_entry),
    .flat_out (core_dout)
  );
endmodule

// File: rtl/psm_chk.sv
module psm_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned PW      = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_rd,
  input logic                  bus_wr,
  input logic                  ctrl_acc,
  input logic                  core_busy,
  input logic                  core_load,
  input logic [ENTRIES*DW-1:0] core_din,
  input logic [ENTRIES*DW-1:0] core_dout,
  input logic [DW-1:0]         rdata,
  input logic [PW-1:0]         rptr,
  input logic [PW-1:0]         wptr
);
  localparam logic [PW-1:0] LAST_IDX = PW'(ENTRIES - 1);

  assert_ctrl_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc |=> (rptr == '0) && (wptr == '0));

  assert_ctrl_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_acc && !bus_wr && !core_load) |=> $stable(core_dout));

  assert_rptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr == LAST_IDX && bus_rd && !bus_wr && !core_busy && !ctrl_acc) |=> (rptr == '0));

  assert_busy_rdata_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |-> (rdata == '0));

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_busy && !ctrl_acc && !core_load) |=> ($stable(core_dout) && $stable(rptr) && $stable(wptr)));

  assert_read_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !core_load) |=> $stable(core_dout));

  assert_load_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |=> (core_dout == $past(core_din)));

  assert_load_ptrs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_load && !bus_rd && !bus_wr && !ctrl_acc) |=> ($stable(rptr) && $stable(wptr)));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (rdata == '0));
endmodule

bind ptr_state_mem psm_chk #(.ENTRIES(ENTRIES), .DW(DW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .ctrl_acc  (ctrl_acc),
  .core_busy (core_busy),
  .core_load (core_load),
  .core_din  (core_din),
  .core_dout (core_dout),
  .rdata     (rdata),
  .rptr      (rptr_q),
  .wptr      (wptr_q)
);

// File: tb/ptr_state_mem_bench.sv
`timescale 1ns/1ps
module ptr_state_mem_bench;
  logic         clk;
  logic         rst_n;
  logic         bus_rd, bus_wr, xor_en, ctrl_acc, core_busy, core_load;
  logic [7:0]   wdata, rdata;
  logic [127:0] core_din, core_dout;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 0;

  logic [7:0] exp_mem [16];
  int         erp, ewp;

  ptr_state_mem u_ptr_state_mem (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .xor_en(xor_en),
    .wdata(wdata), .rdata(rdata), .ctrl_acc(ctrl_acc), .core_busy(core_busy),
    .core_load(core_load), .core_din(core_din), .core_dout(core_dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [127:0] pack_exp();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[(15 - i) * 8 +: 8] = exp_mem[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample rdata 1 ns later, release after posedge
  task automatic cyc(input logic rd, input logic wr, input logic x, input logic [7:0] d,
                     input logic bz, input logic ctl, input logic ld, input logic [127:0] v,
                     output logic [7:0] got);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; xor_en = x; wdata = d;
    core_busy = bz; ctrl_acc = ctl; core_load = ld; core_din = v;
    #1 got = rdata;
    @(posedge clk);
    #1;
    bus_rd = 0; bus_wr = 0; xor_en = 0; wdata = '0;
    core_busy = 0; ctrl_acc = 0; core_load = 0; core_din = '0;
  endtask

  task automatic bus_write(input logic [7:0] d, input logic x, input string req);
    logic [7:0] g;
    logic [7:0] nv;
    nv = x ? (d ^ exp_mem[erp]) : d;
    cyc(0, 1, x, d, 0, 0, 0, '0, g);
    check("R10", {120'd0, g}, 128'd0);
    exp_mem[ewp] = nv;
    ewp = (ewp + 1) % 16;
    if (x) erp = (erp + 1) % 16;
    @(negedge clk);
    check(req, core_dout, pack_exp());
  endtask

  task automatic bus_read(input string req);
    logic [7:0] g;
    cyc(1, 0, 0, '0, 0, 0, 0, '0, g);
    check(req, {120'd0, g}, {120'd0, exp_mem[erp]});
    erp = (erp + 1) % 16;
  endtask

  task automatic ctrl_touch();
    logic [7:0] g;
    cyc(0, 0, 0, '0, 0, 1, 0, '0, g);
    erp = 0; ewp = 0;
    @(negedge clk);
    check("R5 contents kept", core_dout, pack_exp());
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]   g;
    logic [127:0] lv;
    rst_n = 0;
    bus_rd = 0; bus_wr = 0; xor_en = 0; wdata = '0;
    core_busy = 0; ctrl_acc = 0; core_load = 0; core_din = '0;
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    erp = 0; ewp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 contents", core_dout, 128'd0);
    check("R10 idle", {120'd0, rdata}, 128'd0);

    // R2/R8: plain fill of all sixteen entries
    for (int i = 0; i < 16; i++) bus_write(8'((i * 37 + 5) & 255), 0, "R2 R8");
    // R3: read back in order, then R4: read past the end
    for (int i = 0; i < 16; i++) bus_read("R3");
    for (int i = 0; i < 16; i++) bus_read("R4 read wrap");
    // R4: write wrap, twenty writes
    for (int i = 0; i < 20; i++) bus_write(8'((i * 11 + 100) & 255), 0, "R4 write wrap");
    for (int i = 0; i < 3; i++) bus_read("R3 offset");

    // R5: control access clears both pointers
    ctrl_touch();
    bus_read("R5 rptr cleared");
    bus_write(8'h5A, 0, "R5 wptr cleared");
    ctrl_touch();

    // R6: XOR writes with read pointer three ahead of write pointer
    for (int i = 0; i < 3; i++) bus_read("R3");
    for (int i = 0; i < 16; i++) bus_write(8'((i * 53 + 7) & 255), 1, "R6 xor");
    bus_read("R6 rptr advanced");

    // R7: busy blocks reads, writes and pointer motion
    ctrl_touch();
    bus_read("R3"); bus_read("R3");
    cyc(1, 0, 0, '0, 1, 0, 0, '0, g);
    check("R7 busy read zero", {120'd0, g}, 128'd0);
    cyc(0, 1, 0, 8'hAA, 1, 0, 0, '0, g);
    cyc(0, 1, 1, 8'h3C, 1, 0, 0, '0, g);
    @(negedge clk);
    check("R7 busy write dropped", core_dout, pack_exp());
    bus_read("R7 rptr held");
    bus_write(8'hC3, 0, "R7 wptr held");
    // R5 while busy
    cyc(0, 0, 0, '0, 1, 1, 0, '0, g);
    erp = 0; ewp = 0;
    bus_read("R5 clear under busy");

    // R9: parallel load under busy, pointers kept
    ctrl_touch();
    bus_read("R3"); bus_read("R3");
    for (int i = 0; i < 16; i++) lv[(15 - i) * 8 +: 8] = 8'((i * 29 + 200) & 255);
    cyc(0, 0, 0, '0, 1, 0, 1, lv, g);
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'((i * 29 + 200) & 255);
    @(negedge clk);
    check("R9 R8 load", core_dout, pack_exp());
    bus_read("R9 rptr kept");
    bus_write(8'h77, 0, "R9 wptr kept");
    ctrl_touch();
    for (int i = 0; i < 16; i++) bus_read("R9 order");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule